// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a byte-wide register target that runs one serial flash command at a time over a four-wire SPI link. Software first places the command byte in its own register. It loads any payload bytes into a small shared byte buffer through a single data port, and packs the transmit and receive byte counts into one register. Writing the start bit then launches the transfer. The engine sends the command byte, then the payload from buffer index 0 upward. It then clocks in the requested response bytes and stores them in the same buffer, again from index 0, so the payload is overwritten.

Software moves through the buffer with a pointer that it resets and advances by writing strobe bits; the data port never moves the pointer by itself. The serial clock is a division of the system clock by 2, 3 or 4. There are two 2-bit rate fields, a fast one and a normal one. A level input chooses which field applies, and the choice is taken when the command starts.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1 and sclk is 0. The command, count and control registers read 0x00. Offset 0x0D reads 0x70: normal rate code 3 in bits 5:4, fast rate code 1 in bits 7:6, pointer 0 in bits 2:0.
- R2: A write to offset 0x0C stores the byte at the buffer pointer, and a read of 0x0C returns the byte at the pointer. Neither access moves the pointer.
- R3: Writing offset 0x03 with bit 4 set resets the pointer to 0. With bit 5 set (and bit 4 clear) the pointer advances by one, wrapping from 7 to 0. If both bits are set, the reset wins. Bits 2:0 of offset 0x0D show the pointer.
- R4: Writing offset 0x02 with bit 0 set starts a command. Bit 0 of 0x02 reads 1 while cs_n is low and 0 once it has risen. Bit 3 of 0x02 is stored and read back, and has no effect on the link.
- R5: The command byte (offset 0x00) goes out first, followed by the transmit payload taken from buffer index 0 upward. Every byte goes MSB first in SPI mode 0, with mosi stable on each rising sclk edge. mosi is 0 during receive bytes.
- R6: Receive bits are captured while sclk is high, MSB first, and the bytes are stored in the buffer from index 0 upward.
- R7: Offset 0x01 holds the transmit payload count in bits 3:0 and the receive count in bits 7:4. A count above 8 acts as 8.
- R8: Rate code 1 divides the system clock by 2, code 2 by 3, and codes 3 and 0 by 4. The fast field is used while speed_norm is 0 and the normal field while it is 1. cs_n stays low for exactly 8*(1+tx+rx)*N system clocks.
- R9: cs_n falls in the clock after the start write, and the first rising sclk edge follows after a low phase of N-floor(N/2) clocks. sclk is 0 whenever cs_n is 1.
- R10: While a command runs, writes to offsets 0x00, 0x01 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| speed_norm | input | 1 | 1 selects the normal rate field, 0 the fast one |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |

## Verification
The bench runs four patterns:
- A bare read with no payload at the fastest rate, which shows the command byte ordering and the capture of response bytes into the buffer.
- A payload command at divide-by-3, which shows the payload order, the zeros on mosi during receive, and which payload bytes survive the receive overwrite.
- Oversized counts at divide-by-4 through the normal field, which show the saturation at 8 and the rate selection by speed_norm.
- A command hit with register writes while busy, which separates ignored writes from stored ones.

A model flash device records mosi on every rising edge and drives its response on falling edges. The chip-select low time and the first-edge delay are counted in system clocks, which exposes any error in the divider.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int DIV_W = 3;

  localparam logic [3:0] OFS_OPC    = 4'h0;
  localparam logic [3:0] OFS_CNT    = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_PTRCTL = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_SPEED  = 4'hD;

  // system clocks per serial bit for a rate code
  function automatic logic [DIV_W-1:0] div_of_code(input logic [1:0] code);
    case (code)
      2'd1:    return DIV_W'(2);
      2'd2:    return DIV_W'(3);
      default: return DIV_W'(4);
    endcase
  endfunction

  // clocks of the low phase at the start of each bit
  function automatic logic [DIV_W-1:0] low_len(input logic [DIV_W-1:0] n);
    return n - (n >> 1);
  endfunction

  // saturate a byte count at the buffer depth
  function automatic logic [3:0] clamp_cnt(input logic [3:0] c, input logic [3:0] lim);
    return (c > lim) ? lim : c;
  endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             speed_norm,
  input  logic             busy,
  input  logic [PTR_W-1:0] eng_idx,
  output logic [7:0]       eng_rdata,
  input  logic             rx_we,
  input  logic [PTR_W-1:0] rx_idx,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       opcode,
  output logic [3:0]       tx_cnt,
  output logic [3:0]       rx_cnt,
  output logic [1:0]       rate_code,
  output logic             start
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [1:0]       rate_norm, rate_fast;
  logic             arb_flag;

  logic wr_opc, wr_cnt, wr_ctrl, wr_ptr, wr_data, wr_speed;
  assign wr_opc   = bus_wr && (bus_addr == OFS_OPC)    && !busy;
  assign wr_cnt   = bus_wr && (bus_addr == OFS_CNT)    && !busy;
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_ptr   = bus_wr && (bus_addr == OFS_PTRCTL);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA)   && !busy;
  assign wr_speed = bus_wr && (bus_addr == OFS_SPEED);

  assign start     = wr_ctrl && bus_wdata[0] && !busy;
  assign rate_code = speed_norm ? rate_norm : rate_fast;
  assign eng_rdata = mem[eng_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode    <= '0;
      tx_cnt    <= '0;
      rx_cnt    <= '0;
      arb_flag  <= 1'b0;
      rate_norm <= 2'd3;
      rate_fast <= 2'd1;
    end else begin
      if (wr_opc)   opcode <= bus_wdata;
      if (wr_cnt)   {rx_cnt, tx_cnt} <= bus_wdata;
      if (wr_ctrl)  arb_flag <= bus_wdata[3];
      if (wr_speed) {rate_fast, rate_norm} <= bus_wdata[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_ptr) begin
      if (bus_wdata[4])      ptr <= '0;
      else if (bus_wdata[5]) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (rx_we) begin
      mem[rx_idx] <= rx_byte;
    end else if (wr_data) begin
      mem[ptr] <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_OPC:   bus_rdata = opcode;
      OFS_CNT:   bus_rdata = {rx_cnt, tx_cnt};
      OFS_CTRL:  bus_rdata = {4'b0, arb_flag, 2'b0, busy};
      OFS_DATA:  bus_rdata = mem[ptr];
      OFS_SPEED: bus_rdata = {rate_fast, rate_norm, 4'(ptr)};
      default:   bus_rdata = 8'h00;
    endcase
  end

  // R10: count register holds while a command runs
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CNT && busy) |=> ({rx_cnt, tx_cnt} == $past({rx_cnt, tx_cnt})));

  // R3: pointer reset strobe
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PTRCTL && bus_wdata[4]) |=> (ptr == '0));

  // R3: pointer advance strobe
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PTRCTL && bus_wdata[5] && !bus_wdata[4])
      |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

endmodule

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lo;

  assign lo      = low_len(div);
  assign bit_end = run && (cnt == div - 1'b1);
  assign sclk    = run && (cnt >= lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (bit_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int BYTE_W = $clog2(2 * DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [3:0]       tx_cnt,
  input  logic [3:0]       rx_cnt,
  input  logic [1:0]       rate_code,
  input  logic [7:0]       fifo_rdata,
  input  logic             miso,
  input  logic             bit_end,
  output logic             run,
  output logic [DIV_W-1:0] div,
  output logic [PTR_W-1:0] fifo_idx,
  output logic             rx_we,
  output logic [PTR_W-1:0] rx_idx,
  output logic [7:0]       rx_byte,
  output logic             mosi
);

  localparam logic [3:0] LIM = 4'(DEPTH);

  logic [BYTE_W-1:0] byte_idx;
  logic [2:0]        bit_idx;
  logic [3:0]        tx_n, rx_n;
  logic [6:0]        rx_sh;
  logic [BYTE_W-1:0] last_byte;
  logic              in_opc, in_rx, last_bit;
  logic [7:0]        cur_tx;

  assign last_byte = BYTE_W'(tx_n) + BYTE_W'(rx_n);
  assign in_opc    = (byte_idx == '0);
  assign in_rx     = (byte_idx > BYTE_W'(tx_n));
  assign last_bit  = (bit_idx == 3'd7);
  assign fifo_idx  = PTR_W'(byte_idx - 1'b1);
  assign rx_idx    = PTR_W'(byte_idx - BYTE_W'(tx_n) - 1'b1);
  assign cur_tx    = in_opc ? opcode : fifo_rdata;
  assign mosi      = run && !in_rx && cur_tx[3'd7 - bit_idx];
  assign rx_byte   = {rx_sh, miso};
  assign rx_we     = run && in_rx && bit_end && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      tx_n     <= '0;
      rx_n     <= '0;
      div      <= DIV_W'(4);
      rx_sh    <= '0;
    end else if (start) begin
      run      <= 1'b1;
      byte_idx <= '0;
      bit_idx  <= '0;
      tx_n     <= clamp_cnt(tx_cnt, LIM);
      rx_n     <= clamp_cnt(rx_cnt, LIM);
      div      <= div_of_code(rate_code);
    end else if (run && bit_end) begin
      rx_sh   <= {rx_sh[5:0], miso};
      bit_idx <= bit_idx + 1'b1;
      if (last_bit) begin
        if (byte_idx == last_byte) run <= 1'b0;
        else                       byte_idx <= byte_idx + 1'b1;
      end
    end
  end

  // R4: a start request always opens a transfer
  assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && byte_idx == '0 && bit_idx == '0));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       speed_norm,
  input  logic       miso,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi
);

  logic             run, start, rx_we, bit_end;
  logic [7:0]       opcode, eng_rdata, rx_byte;
  logic [3:0]       tx_cnt, rx_cnt;
  logic [1:0]       rate_code;
  logic [PTR_W-1:0] fifo_idx, rx_idx;
  logic [DIV_W-1:0] div;

  spi_eng_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(reg_addr), .bus_wr(reg_wr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .speed_norm(speed_norm), .busy(run),
    .eng_idx(fifo_idx), .eng_rdata(eng_rdata),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .rate_code(rate_code), .start(start)
  );

  spi_eng_seq #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rate_code(rate_code),
    .fifo_rdata(eng_rdata), .miso(miso), .bit_end(bit_end),
    .run(run), .div(div), .fifo_idx(fifo_idx),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte), .mosi(mosi)
  );

  spi_eng_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div),
    .sclk(sclk), .bit_end(bit_end)
  );

  assign cs_n = !run;

  // R9: no serial clock activity outside a selected frame
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R6: response bytes are only written inside a frame
  assert_rx_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (!cs_n && !mosi));

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       speed_norm = 1'b0;
  logic       miso = 1'b0;
  logic       sclk, cs_n, mosi;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .speed_norm(speed_norm),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  // flash device model
  logic [7:0] rsp [8];
  logic [7:0] mlog [17];
  int slv_bits = 0;
  int hdr = 1;

  initial forever begin
    @(posedge sclk);
    mlog[slv_bits / 8][7 - (slv_bits % 8)] = mosi;
    slv_bits = slv_bits + 1;
  end

  initial forever begin
    @(negedge sclk);
    begin
      int k;
      k = slv_bits - 8 * hdr;
      if (k >= 0 && k < 64) miso <= rsp[k / 8][7 - (k % 8)];
      else                  miso <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // run one command; returns cs_n low time and first rising sample
  task automatic run_cmd(input logic [7:0] opc, input int tx, input int rx,
                         input logic norm, output int cyc, output int first_hi);
    logic [7:0] d;
    hdr = 1 + ((tx > 8) ? 8 : tx);
    slv_bits = 0;
    speed_norm = norm;
    bw(4'h0, opc);
    bw(4'h1, 8'((rx << 4) | tx));
    bw(4'h2, 8'h01);
    reg_addr = 4'h2;
    #1 chk("R4 busy bit while running", int'(reg_rdata[0]), 1);
    cyc = 0;
    first_hi = 0;
    while (cs_n == 1'b0 && cyc < 4000) begin
      cyc++;
      if (sclk && first_hi == 0) first_hi = cyc;
      @(negedge clk);
    end
    br(4'h2, d);
    chk("R4 busy bit clear after frame", int'(d[0]), 0);
  endtask

  task automatic buf_read(input int idx, output logic [7:0] d);
    bw(4'h3, 8'h10);
    for (int i = 0; i < idx; i++) bw(4'h3, 8'h20);
    br(4'hC, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cs_n idle", int'(cs_n), 1);
    chk("R1 sclk idle", int'(sclk), 0);
    br(4'h0, d); chk("R1 command reg", int'(d), 8'h00);
    br(4'h1, d); chk("R1 count reg", int'(d), 8'h00);
    br(4'h2, d); chk("R1 control reg", int'(d), 8'h00);
    br(4'hD, d); chk("R1 rate/pointer reg", int'(d), 8'h70);
  endtask

  task automatic t_port();
    logic [7:0] d;
    bw(4'h3, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bw(4'hC, 8'hA0 + 8'(i));
      bw(4'h3, 8'h20);
    end
    br(4'hD, d); chk("R3 pointer wraps to 0", int'(d[2:0]), 0);
    for (int i = 0; i < 8; i++) begin
      br(4'hC, d); chk("R2 readback at pointer", int'(d), 8'hA0 + i);
      br(4'hC, d); chk("R2 read keeps pointer", int'(d), 8'hA0 + i);
      bw(4'h3, 8'h20);
    end
    bw(4'h3, 8'h20); bw(4'h3, 8'h20);
    br(4'hD, d); chk("R3 pointer advanced", int'(d[2:0]), 2);
    bw(4'h3, 8'h30);
    br(4'hD, d); chk("R3 reset wins over advance", int'(d[2:0]), 0);
  endtask

  task automatic t_read_id();
    int cyc, fh;
    logic [7:0] d;
    rsp[0] = 8'hC2; rsp[1] = 8'h20; rsp[2] = 8'h18;
    run_cmd(8'h9F, 0, 3, 1'b0, cyc, fh);
    chk("R8 fast code 1 frame length", cyc, 4 * 8 * 2);
    chk("R9 first rise after low phase", fh, 2);
    chk("R5 command byte on mosi", int'(mlog[0]), 8'h9F);
    for (int i = 0; i < 3; i++) begin
      buf_read(i, d); chk("R6 response byte stored", int'(d), int'(rsp[i]));
    end
  endtask

  task automatic t_payload();
    int cyc, fh;
    logic [7:0] d;
    bw(4'hD, 8'hB0);
    bw(4'h3, 8'h10);
    bw(4'hC, 8'h00); bw(4'h3, 8'h20);
    bw(4'hC, 8'h12); bw(4'h3, 8'h20);
    bw(4'hC, 8'h34); bw(4'h3, 8'h20);
    bw(4'hC, 8'h56);
    rsp[0] = 8'h5A; rsp[1] = 8'hA5;
    run_cmd(8'h0B, 4, 2, 1'b0, cyc, fh);
    chk("R8 fast code 2 frame length", cyc, 7 * 8 * 3);
    chk("R9 first rise divide by 3", fh, 3);
    chk("R5 command first", int'(mlog[0]), 8'h0B);
    chk("R5 payload 0", int'(mlog[1]), 8'h00);
    chk("R5 payload 1", int'(mlog[2]), 8'h12);
    chk("R5 payload 2", int'(mlog[3]), 8'h34);
    chk("R5 payload 3", int'(mlog[4]), 8'h56);
    chk("R5 mosi low in receive", int'(mlog[5] | mlog[6]), 0);
    buf_read(0, d); chk("R6 overwrite index 0", int'(d), 8'h5A);
    buf_read(1, d); chk("R6 overwrite index 1", int'(d), 8'hA5);
    buf_read(2, d); chk("R6 payload kept index 2", int'(d), 8'h34);
    buf_read(3, d); chk("R6 payload kept index 3", int'(d), 8'h56);
  endtask

  task automatic t_clamp();
    int cyc, fh;
    logic [7:0] d;
    bw(4'hD, 8'h70);
    bw(4'h3, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bw(4'hC, 8'h30 + 8'(i));
      bw(4'h3, 8'h20);
    end
    for (int i = 0; i < 8; i++) rsp[i] = 8'hE0 + 8'(i);
    run_cmd(8'h02, 15, 15, 1'b1, cyc, fh);
    chk("R7 R8 clamped frame at normal code 3", cyc, 17 * 8 * 4);
    chk("R5 last payload byte", int'(mlog[8]), 8'h37);
    buf_read(7, d); chk("R7 eighth response byte", int'(d), 8'hE7);
    br(4'h1, d); chk("R7 counts kept as written", int'(d), 8'hFF);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    int guard;
    speed_norm = 1'b0;
    bw(4'h3, 8'h10);
    for (int i = 0; i < 5; i++) bw(4'h3, 8'h20);
    bw(4'hC, 8'h77);
    bw(4'h0, 8'h05);
    bw(4'h1, 8'h10);
    hdr = 1; slv_bits = 0; rsp[0] = 8'h3C;
    bw(4'h2, 8'h01);
    bw(4'h1, 8'h88);
    bw(4'hC, 8'hEE);
    bw(4'h0, 8'hAA);
    chk("R10 still busy during writes", int'(cs_n), 0);
    guard = 0;
    while (cs_n == 1'b0 && guard < 4000) begin guard++; @(negedge clk); end
    br(4'h1, d); chk("R10 count write ignored", int'(d), 8'h10);
    br(4'h0, d); chk("R10 command write ignored", int'(d), 8'h05);
    br(4'hC, d); chk("R10 data write ignored", int'(d), 8'h77);
    buf_read(0, d); chk("R6 status byte", int'(d), 8'h3C);
  endtask

  task automatic t_arb();
    logic [7:0] d;
    bw(4'h2, 8'h08);
    br(4'h2, d); chk("R4 arbitration flag stored", int'(d), 8'h08);
    repeat (4) @(negedge clk);
    chk("R4 arbitration flag starts nothing", int'(cs_n), 1);
    bw(4'h2, 8'h00);
    br(4'h2, d); chk("R4 arbitration flag cleared", int'(d), 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rsp[i] = '0;
    for (int i = 0; i < 17; i++) mlog[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port();
    t_read_id();
    t_payload();
    t_clamp();
    t_busy_ignore();
    t_arb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule